// File: doc/BRIEF.md
# Atomic Halfword Bit-Clear Unit

This block takes one 32-bit instruction word for an atomic bit-clear on a 16-bit halfword. It combines decode and execution in a single unit. It first confirms that the word carries the expected fixed opcode bits and that the atomic extension is enabled. It then extracts the operand, base and destination register indices and the two memory-ordering bits. After that it runs a locked read-modify-write on a single-request memory port.

The new memory value is the loaded halfword with every bit cleared that is set in the low halfword of the operand register. The original halfword is zero-extended and returned to the destination register, unless the destination is register 31. The base address comes from a general register, or from the stack pointer when the base index is 31. The stack pointer must be 16-byte aligned, and a misaligned stack pointer aborts the instruction before any access.

A host hands over one word with a start strobe while the unit is idle. It then waits for the one-cycle done pulse. At that pulse the undefined and alignment-fault qualifiers are valid.

Top module: `hbclr_atomic_unit`

## Requirements
- R1: A word is this instruction only if bits 31:24 equal 0x78, bit 21 is 1, bit 15 is 0, bits 14:12 equal 001 and bits 11:10 equal 00. Any other word ends with undef_o high at done_o, with no memory request and no writeback.
- R2: When feat_en_i is low at the start strobe, the instruction ends with undef_o high at done_o, with no memory request and no writeback.
- R3: While busy on a legal word, acq_o is 1 exactly when bit 23 is 1 and the destination field (bits 4:0) is not 31, and rel_o equals bit 22. Both are 0 when idle.
- R4: While busy on a legal word, st_alias_o is 1 exactly when bit 23 is 0 and the destination field is 31.
- R5: The halfword written back to memory is the loaded halfword AND the complement of rs_val_i. rs_val_i is the low 16 bits of the register indexed by bits 20:16.
- R6: The loaded halfword, zero-extended to 32 bits, is written once to the register indexed by bits 4:0. No writeback occurs when that index is 31.
- R7: When the base field (bits 9:5) is 31, the address is sp_i. Otherwise it is the full 64-bit rn_val_i of that register.
- R8: With base field 31 and a nonzero value in sp_i bits 3:0, the instruction ends with align_fault_o high at done_o, with no read, no write and no writeback.
- R9: The memory sequence is exactly one read followed by one write to the same address. mem_lock_o stays high from the read request until the write is acknowledged. A request holds its address and direction until it is acknowledged.
- R10: done_o pulses for exactly one cycle after the writeback. A start strobe while busy_o is high is ignored.
- R11: After reset, busy_o, done_o, mem_req_o and wb_en_o are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Hand over insn_i (taken only when idle) |
| insn_i | input | 32 | Instruction word |
| feat_en_i | input | 1 | Atomic extension enabled |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle completion pulse |
| undef_o | output | 1 | Word undefined (valid with done_o) |
| align_fault_o | output | 1 | Stack pointer misaligned (valid with done_o) |
| rs_idx_o | output | 5 | Operand register index |
| rs_val_i | input | 16 | Low halfword of operand register |
| rn_idx_o | output | 5 | Base register index |
| rn_val_i | input | 64 | Base register value |
| sp_i | input | 64 | Stack pointer |
| mem_req_o | output | 1 | Memory request |
| mem_we_o | output | 1 | Request is a write |
| mem_lock_o | output | 1 | Atomic lock |
| mem_addr_o | output | 64 | Byte address |
| mem_wdata_o | output | 16 | Write data |
| mem_rdata_i | input | 16 | Read data (valid with ack) |
| mem_ack_i | input | 1 | Request accepted/completed |
| wb_en_o | output | 1 | Register writeback strobe |
| wb_idx_o | output | 5 | Writeback register index |
| wb_data_o | output | 32 | Zero-extended old halfword |
| acq_o | output | 1 | Acquire ordering |
| rel_o | output | 1 | Release ordering |
| st_alias_o | output | 1 | Store-only alias form |

## Verification
The bench builds the unit with its default parameters: 64-bit addresses, a 16-bit data path and a 16-byte stack-pointer alignment. With the full 64-bit address width, a base register with high address bits set shows that the address passes through untruncated. With the 16-byte alignment, a stack pointer that is 8-byte but not 16-byte aligned hits the fault path. With the 16-bit data width against a 32-bit writeback, the zero upper half of the returned value can be checked. Memory latencies of zero and three cycles exercise the lock across held requests.

// File: rtl/hbclr_pkg.sv
// Package: shared constants and types for the atomic halfword bit-clear unit.
// Assumes the fixed 32-bit instruction layout; field widths are set by that layout.
package hbclr_pkg;
    localparam int          INSN_W  = 32;
    localparam int          REG_AW  = 5;
    localparam logic [7:0]  OPC_TOP = 8'b0111_1000;
    localparam logic [2:0]  OPC_MID = 3'b001;
    localparam logic [REG_AW-1:0] REG_ZR = 5'd31;

    // Decoded view of one instruction word.
    typedef struct packed {
        logic              hit;
        logic              acq;
        logic              rel;
        logic              st_alias;
        logic [REG_AW-1:0] rs;
        logic [REG_AW-1:0] rn;
        logic [REG_AW-1:0] rt;
    } hb_dec_t;

    typedef enum logic [2:0] {
        ST_IDLE, ST_CHECK, ST_RD, ST_WR, ST_WB, ST_DONE
    } hb_state_t;
endpackage

// File: rtl/hbclr_decode.sv
// Module: hbclr_decode
// Purely combinational field decoder. Matches the fixed opcode bits, splits out
// register indices and derives the ordering and alias flags.
// Assumes: insn_i is stable for as long as the result is used.
module hbclr_decode
    import hbclr_pkg::*;
(
    input  logic [INSN_W-1:0] insn_i,
    output hb_dec_t           dec_o
);
    logic a_bit;
    logic r_bit;

    // Field extraction and flag derivation.
    always_comb begin
        a_bit           = insn_i[23];
        r_bit           = insn_i[22];
        dec_o.hit       = (insn_i[31:24] == OPC_TOP) && insn_i[21] && !insn_i[15]
                          && (insn_i[14:12] == OPC_MID) && (insn_i[11:10] == 2'b00);
        dec_o.rs        = insn_i[20:16];
        dec_o.rn        = insn_i[9:5];
        dec_o.rt        = insn_i[4:0];
        dec_o.acq       = a_bit && (insn_i[4:0] != REG_ZR);
        dec_o.rel       = r_bit;
        dec_o.st_alias  = !a_bit && (insn_i[4:0] == REG_ZR);
    end
endmodule

// File: rtl/hbclr_addr_sel.sv
// Module: hbclr_addr_sel
// Chooses the base address (stack pointer or general register) and flags a
// misaligned stack pointer. ALIGN_LOG2 = 0 removes the check.
// Assumes: gpr_i and sp_i are settled in the cycle the result is sampled.
module hbclr_addr_sel #(
    parameter int XLEN       = 64,
    parameter int ALIGN_LOG2 = 4
) (
    input  logic            use_sp_i,
    input  logic [XLEN-1:0] sp_i,
    input  logic [XLEN-1:0] gpr_i,
    output logic [XLEN-1:0] addr_o,
    output logic            misalign_o
);
    // Base mux.
    assign addr_o = use_sp_i ? sp_i : gpr_i;

    generate
        if (ALIGN_LOG2 > 0) begin : g_chk
            // Any set low bit of the stack pointer is a misalignment.
            assign misalign_o = use_sp_i && (|sp_i[ALIGN_LOG2-1:0]);
        end else begin : g_nochk
            assign misalign_o = 1'b0;
        end
    endgenerate
endmodule

// File: rtl/hbclr_seq.sv
// Module: hbclr_seq
// Sequencer and datapath: accept, check, locked read, write, writeback, done.
// Assumes: the memory holds a request's result until mem_ack_i; register-file
// reads are combinational on the index outputs.
module hbclr_seq
    import hbclr_pkg::*;
#(
    parameter int XLEN = 64,
    parameter int HW   = 16,
    parameter int WBW  = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [INSN_W-1:0] insn_i,
    input  logic              feat_i,
    input  hb_dec_t           dec_i,
    input  logic [HW-1:0]     op_i,
    input  logic [XLEN-1:0]   addr_i,
    input  logic              misalign_i,
    output logic [INSN_W-1:0] insn_q_o,
    output logic              legal_o,
    output logic              mem_req_o,
    output logic              mem_we_o,
    output logic              mem_lock_o,
    output logic [XLEN-1:0]   mem_addr_o,
    output logic [HW-1:0]     mem_wdata_o,
    input  logic [HW-1:0]     mem_rdata_i,
    input  logic              mem_ack_i,
    output logic              wb_en_o,
    output logic [WBW-1:0]    wb_data_o,
    output logic              busy_o,
    output logic              done_o,
    output logic              undef_o,
    output logic              fault_o
);
    localparam int PAD_W = WBW - HW;

    hb_state_t         state_q;
    logic [INSN_W-1:0] insn_q;
    logic              feat_q;
    logic [HW-1:0]     op_q;
    logic [XLEN-1:0]   addr_q;
    logic [HW-1:0]     old_q;
    logic              undef_q;
    logic              fault_q;

    // State machine: advances one phase of the atomic sequence per step.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            case (state_q)
                ST_IDLE:  if (start_i) state_q <= ST_CHECK;
                ST_CHECK: begin
                    if (!(feat_q && dec_i.hit) || misalign_i) state_q <= ST_DONE;
                    else                                      state_q <= ST_RD;
                end
                ST_RD:    if (mem_ack_i) state_q <= ST_WR;
                ST_WR:    if (mem_ack_i) state_q <= ST_WB;
                ST_WB:    state_q <= ST_DONE;
                ST_DONE:  state_q <= ST_IDLE;
                default:  state_q <= ST_IDLE;
            endcase
        end
    end

    // Captures the instruction and feature bit at acceptance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            insn_q <= '0;
            feat_q <= 1'b0;
        end else if (state_q == ST_IDLE && start_i) begin
            insn_q <= insn_i;
            feat_q <= feat_i;
        end
    end

    // Latches operand and address in the check phase, and the outcome flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            op_q    <= '0;
            addr_q  <= '0;
            undef_q <= 1'b0;
            fault_q <= 1'b0;
        end else if (state_q == ST_IDLE && start_i) begin
            undef_q <= 1'b0;
            fault_q <= 1'b0;
        end else if (state_q == ST_CHECK) begin
            op_q    <= op_i;
            addr_q  <= addr_i;
            undef_q <= !(feat_q && dec_i.hit);
            fault_q <= feat_q && dec_i.hit && misalign_i;
        end
    end

    // Holds the halfword returned by the locked read.
    always_ff @(posedge clk) begin
        if (!rst_n)                          old_q <= '0;
        else if (state_q == ST_RD && mem_ack_i) old_q <= mem_rdata_i;
    end

    // Output decode from state and held data.
    always_comb begin
        busy_o      = (state_q != ST_IDLE);
        done_o      = (state_q == ST_DONE);
        undef_o     = done_o && undef_q;
        fault_o     = done_o && fault_q;
        mem_req_o   = (state_q == ST_RD) || (state_q == ST_WR);
        mem_we_o    = (state_q == ST_WR);
        mem_lock_o  = mem_req_o;
        mem_addr_o  = addr_q;
        mem_wdata_o = old_q & ~op_q;
        wb_en_o     = (state_q == ST_WB) && (dec_i.rt != REG_ZR);
        wb_data_o   = {{PAD_W{1'b0}}, old_q};
        legal_o     = busy_o && feat_q && dec_i.hit;
        insn_q_o    = insn_q;
    end
endmodule

// File: rtl/hbclr_atomic_unit.sv
// Module: hbclr_atomic_unit (top)
// Fused decode-and-execute atomic bit-clear on a halfword over a locked
// single-request memory port, with register writeback of the old value.
// Assumes: one instruction at a time; the caller waits for done_o.
module hbclr_atomic_unit
    import hbclr_pkg::*;
#(
    parameter int XLEN          = 64,
    parameter int HW            = 16,
    parameter int WBW           = 32,
    parameter int SP_ALIGN_LOG2 = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [31:0]       insn_i,
    input  logic              feat_en_i,
    output logic              busy_o,
    output logic              done_o,
    output logic              undef_o,
    output logic              align_fault_o,
    output logic [4:0]        rs_idx_o,
    input  logic [HW-1:0]     rs_val_i,
    output logic [4:0]        rn_idx_o,
    input  logic [XLEN-1:0]   rn_val_i,
    input  logic [XLEN-1:0]   sp_i,
    output logic              mem_req_o,
    output logic              mem_we_o,
    output logic              mem_lock_o,
    output logic [XLEN-1:0]   mem_addr_o,
    output logic [HW-1:0]     mem_wdata_o,
    input  logic [HW-1:0]     mem_rdata_i,
    input  logic              mem_ack_i,
    output logic              wb_en_o,
    output logic [4:0]        wb_idx_o,
    output logic [WBW-1:0]    wb_data_o,
    output logic              acq_o,
    output logic              rel_o,
    output logic              st_alias_o
);
    hb_dec_t           dec;
    logic [INSN_W-1:0] insn_q;
    logic [XLEN-1:0]   base_addr;
    logic              misalign;
    logic              legal;

    hbclr_decode u_dec (
        .insn_i (insn_q),
        .dec_o  (dec)
    );

    hbclr_addr_sel #(.XLEN(XLEN), .ALIGN_LOG2(SP_ALIGN_LOG2)) u_addr (
        .use_sp_i   (dec.rn == REG_ZR),
        .sp_i       (sp_i),
        .gpr_i      (rn_val_i),
        .addr_o     (base_addr),
        .misalign_o (misalign)
    );

    hbclr_seq #(.XLEN(XLEN), .HW(HW), .WBW(WBW)) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_i     (start_i),
        .insn_i      (insn_i),
        .feat_i      (feat_en_i),
        .dec_i       (dec),
        .op_i        (rs_val_i),
        .addr_i      (base_addr),
        .misalign_i  (misalign),
        .insn_q_o    (insn_q),
        .legal_o     (legal),
        .mem_req_o   (mem_req_o),
        .mem_we_o    (mem_we_o),
        .mem_lock_o  (mem_lock_o),
        .mem_addr_o  (mem_addr_o),
        .mem_wdata_o (mem_wdata_o),
        .mem_rdata_i (mem_rdata_i),
        .mem_ack_i   (mem_ack_i),
        .wb_en_o     (wb_en_o),
        .wb_data_o   (wb_data_o),
        .busy_o      (busy_o),
        .done_o      (done_o),
        .undef_o     (undef_o),
        .fault_o     (align_fault_o)
    );

    // Register indices and ordering flags, the flags shown only for a legal word.
    always_comb begin
        rs_idx_o   = dec.rs;
        rn_idx_o   = dec.rn;
        wb_idx_o   = dec.rt;
        acq_o      = legal && dec.acq;
        rel_o      = legal && dec.rel;
        st_alias_o = legal && dec.st_alias;
    end
endmodule

// File: rtl/hbclr_chk.sv
// Module: hbclr_chk
// Protocol checker bound to hbclr_atomic_unit; observes ports only.
module hbclr_chk #(
    parameter int XLEN = 64,
    parameter int WBW  = 32
) (
    input logic            clk,
    input logic            rst_n,
    input logic            busy_o,
    input logic            done_o,
    input logic            mem_req_o,
    input logic            mem_we_o,
    input logic            mem_lock_o,
    input logic [XLEN-1:0] mem_addr_o,
    input logic            mem_ack_i,
    input logic            wb_en_o,
    input logic [4:0]      wb_idx_o,
    input logic [WBW-1:0]  wb_data_o,
    input logic            acq_o,
    input logic            rel_o
);
    // R9
    lock_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(mem_lock_o) |-> $past(mem_we_o && mem_ack_i));
    // R9
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_o && !mem_ack_i) |=> (mem_req_o && $stable(mem_addr_o) && $stable(mem_we_o)));
    // R9
    read_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_req_o) |-> !mem_we_o);
    // R10
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);
    // R6
    wb_zr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wb_en_o |-> (wb_idx_o != 5'd31) && (wb_data_o[WBW-1:16] == '0));
    // R11
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> (!mem_req_o && !wb_en_o && !acq_o && !rel_o));
endmodule

bind hbclr_atomic_unit hbclr_chk #(.XLEN(XLEN), .WBW(WBW)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .busy_o     (busy_o),
    .done_o     (done_o),
    .mem_req_o  (mem_req_o),
    .mem_we_o   (mem_we_o),
    .mem_lock_o (mem_lock_o),
    .mem_addr_o (mem_addr_o),
    .mem_ack_i  (mem_ack_i),
    .wb_en_o    (wb_en_o),
    .wb_idx_o   (wb_idx_o),
    .wb_data_o  (wb_data_o),
    .acq_o      (acq_o),
    .rel_o      (rel_o)
);

// File: tb/sim_hbclr_atomic_unit.sv
// Directed bench: one task per scenario, each checking its own results.
module sim_hbclr_atomic_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [31:0] insn_i = '0;
    logic        feat_en_i = 1'b1;
    logic        busy_o, done_o, undef_o, align_fault_o;
    logic [4:0]  rs_idx_o, rn_idx_o, wb_idx_o;
    logic [15:0] rs_val_i;
    logic [63:0] rn_val_i;
    logic [63:0] sp_i = '0;
    logic        mem_req_o, mem_we_o, mem_lock_o;
    logic [63:0] mem_addr_o;
    logic [15:0] mem_wdata_o;
    logic [15:0] mem_rdata_i = '0;
    logic        mem_ack_i = 1'b0;
    logic        wb_en_o;
    logic [31:0] wb_data_o;
    logic        acq_o, rel_o, st_alias_o;

    logic [63:0] rf [32];
    logic [15:0] mem [512];

    int tests = 0;
    int fails = 0;
    int lat   = 0;

    // Per-operation observations.
    int          n_rd, n_wr, n_wb;
    logic [63:0] rd_addr, wr_addr;
    logic [15:0] wr_data;
    logic [4:0]  wb_idx;
    logic [31:0] wb_data;
    logic        seen_acq, seen_rel, seen_alias, lock_gap, got_undef, got_fault, got_done;

    always #2 clk = ~clk;

    assign rs_val_i = rf[rs_idx_o][15:0];
    assign rn_val_i = rf[rn_idx_o];

    hbclr_atomic_unit u0 (.*);

    initial begin
        #400000;
        fails++;
        $display("FAIL watchdog: run did not complete");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    task automatic chk(input logic ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] mk(input logic a, input logic r, input logic [4:0] rs,
                                       input logic [4:0] rn, input logic [4:0] rt);
        return {8'b0111_1000, a, r, 1'b1, rs, 1'b0, 3'b001, 2'b00, rn, rt};
    endfunction

    // Issue one word, act as memory, record everything until done, then one more cycle.
    task automatic exec(input logic [31:0] w, input logic feat, input logic poke);
        int wait_cnt = 0;
        int cyc = 0;
        n_rd = 0; n_wr = 0; n_wb = 0;
        seen_acq = 0; seen_rel = 0; seen_alias = 0; lock_gap = 0;
        got_undef = 0; got_fault = 0; got_done = 0;
        @(negedge clk);
        insn_i = w; feat_en_i = feat; start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        while (!got_done && cyc < 100) begin
            if (poke && cyc == 1) begin
                insn_i = mk(1'b0, 1'b0, 5'd1, 5'd1, 5'd1); start_i = 1'b1;
            end else begin
                start_i = 1'b0;
            end
            if (busy_o) begin
                seen_acq   |= acq_o;
                seen_rel   |= rel_o;
                seen_alias |= st_alias_o;
            end
            if (n_rd > 0 && n_wr == 0 && !mem_lock_o) lock_gap = 1;
            if (wb_en_o) begin n_wb++; wb_idx = wb_idx_o; wb_data = wb_data_o; end
            if (done_o) begin got_done = 1; got_undef = undef_o; got_fault = align_fault_o; end
            if (mem_req_o) begin
                if (wait_cnt >= lat) begin
                    mem_ack_i = 1'b1; wait_cnt = 0;
                    if (mem_we_o) begin
                        n_wr++; wr_addr = mem_addr_o; wr_data = mem_wdata_o;
                        mem[mem_addr_o[9:1]] = mem_wdata_o;
                    end else begin
                        n_rd++; rd_addr = mem_addr_o; mem_rdata_i = mem[mem_addr_o[9:1]];
                    end
                end else begin
                    mem_ack_i = 1'b0; wait_cnt++;
                end
            end else begin
                mem_ack_i = 1'b0;
            end
            if (!got_done) begin @(negedge clk); cyc++; end
        end
        start_i = 1'b0;
        chk(got_done, "R10 done seen", 64'(got_done), 64'd1);
        @(negedge clk);
        chk(!done_o && !busy_o, "R10 done one cycle", 64'({done_o, busy_o}), 64'd0);
    endtask

    task automatic t_reset();
        chk(!busy_o && !done_o && !mem_req_o && !wb_en_o, "R11 reset outputs",
            64'({busy_o, done_o, mem_req_o, wb_en_o}), 64'd0);
    endtask

    task automatic t_basic(input int latency);
        lat = latency;
        rf[3] = 64'hFFFF_0000_0000_0100; rf[5] = 64'h0000_0000_FFFF_00F0;
        mem[9'h080] = 16'hABCD;
        exec(mk(1'b0, 1'b0, 5'd5, 5'd3, 5'd7), 1'b1, 1'b0);
        chk(n_rd == 1 && n_wr == 1, "R9 one read one write", 64'({n_rd[15:0], n_wr[15:0]}), 64'h0001_0001);
        chk(rd_addr == 64'hFFFF_0000_0000_0100 && wr_addr == rd_addr, "R7 full gpr address", wr_addr, 64'hFFFF_0000_0000_0100);
        chk(!lock_gap, "R9 lock held read to write", 64'(lock_gap), 64'd0);
        chk(wr_data == 16'hAB0D, "R5 cleared bits", 64'(wr_data), 64'hAB0D);
        chk(n_wb == 1 && wb_idx == 5'd7 && wb_data == 32'h0000_ABCD, "R6 zero-extended old value",
            64'(wb_data), 64'h0000_ABCD);
        chk(!got_undef && !got_fault, "R1 legal word accepted", 64'({got_undef, got_fault}), 64'd0);
        lat = 0;
    endtask

    task automatic t_orders();
        for (int k = 0; k < 4; k++) begin
            logic a = k[1];
            logic r = k[0];
            rf[4] = 64'h40; mem[9'h020] = 16'h1234; rf[6] = 64'h0;
            exec(mk(a, r, 5'd6, 5'd4, 5'd2), 1'b1, 1'b0);
            chk(seen_acq == a && seen_rel == r, "R3 ordering flags", 64'({seen_acq, seen_rel}), 64'({a, r}));
            chk(!seen_alias, "R4 no alias with rt=2", 64'(seen_alias), 64'd0);
        end
    endtask

    task automatic t_acq_zr();
        rf[4] = 64'h40; mem[9'h020] = 16'hFFFF; rf[6] = 64'h0000_000F;
        exec(mk(1'b1, 1'b0, 5'd6, 5'd4, 5'd31), 1'b1, 1'b0);
        chk(!seen_acq, "R3 acquire dropped for rt=31", 64'(seen_acq), 64'd0);
        chk(n_wb == 0, "R6 no writeback for rt=31", 64'(n_wb), 64'd0);
        chk(!seen_alias && mem[9'h020] == 16'hFFF0, "R4 no alias with A=1; R5 store done",
            64'(mem[9'h020]), 64'hFFF0);
    endtask

    task automatic t_alias();
        rf[4] = 64'h40; mem[9'h020] = 16'h00FF; rf[6] = 64'h0000_0011;
        exec(mk(1'b0, 1'b1, 5'd6, 5'd4, 5'd31), 1'b1, 1'b0);
        chk(seen_alias && seen_rel && !seen_acq, "R4 alias form flagged",
            64'({seen_alias, seen_rel, seen_acq}), 64'b110);
        chk(mem[9'h020] == 16'h00EE, "R5 alias store value", 64'(mem[9'h020]), 64'h00EE);
    endtask

    task automatic t_sp();
        sp_i = 64'h0000_0000_0000_0200; rf[31] = 64'h0; rf[8] = 64'h0000_0000_0000_8001;
        mem[9'h100] = 16'hF0F0;
        exec(mk(1'b0, 1'b0, 5'd8, 5'd31, 5'd9), 1'b1, 1'b0);
        chk(rd_addr == 64'h200 && n_rd == 1, "R7 stack pointer address", rd_addr, 64'h200);
        chk(wr_data == 16'h70F0 && wb_data == 32'h0000_F0F0, "R5 R6 via stack pointer",
            64'(wr_data), 64'h70F0);
    endtask

    task automatic t_sp_fault();
        sp_i = 64'h0000_0000_0000_0208; mem[9'h104] = 16'h5555;
        exec(mk(1'b0, 1'b0, 5'd8, 5'd31, 5'd9), 1'b1, 1'b0);
        chk(got_fault && !got_undef, "R8 alignment fault", 64'({got_fault, got_undef}), 64'b10);
        chk(n_rd == 0 && n_wr == 0 && n_wb == 0, "R8 no access on fault",
            64'(n_rd + n_wr + n_wb), 64'd0);
        chk(mem[9'h104] == 16'h5555, "R8 memory untouched", 64'(mem[9'h104]), 64'h5555);
    endtask

    task automatic t_feat_off();
        rf[4] = 64'h40; mem[9'h020] = 16'h7777;
        exec(mk(1'b1, 1'b1, 5'd6, 5'd4, 5'd2), 1'b0, 1'b0);
        chk(got_undef && !seen_acq && !seen_rel, "R2 undefined when feature off",
            64'({got_undef, seen_acq, seen_rel}), 64'b100);
        chk(n_rd + n_wr + n_wb == 0 && mem[9'h020] == 16'h7777, "R2 no access",
            64'(n_rd + n_wr + n_wb), 64'd0);
    endtask

    task automatic t_nomatch();
        logic [31:0] base = mk(1'b0, 1'b0, 5'd6, 5'd4, 5'd2);
        exec(base | 32'h0000_8000, 1'b1, 1'b0);
        chk(got_undef && n_rd + n_wr + n_wb == 0, "R1 bit 15 set rejected", 64'(got_undef), 64'd1);
        exec(base & ~32'h0020_0000, 1'b1, 1'b0);
        chk(got_undef && n_rd + n_wr + n_wb == 0, "R1 bit 21 clear rejected", 64'(got_undef), 64'd1);
        exec(base ^ 32'h0000_3000, 1'b1, 1'b0);
        chk(got_undef && n_rd + n_wr + n_wb == 0, "R1 opcode bits 14:12 rejected", 64'(got_undef), 64'd1);
    endtask

    task automatic t_busy_start();
        rf[3] = 64'h100; rf[5] = 64'h0001; rf[1] = 64'h40; mem[9'h080] = 16'h0003; mem[9'h020] = 16'hAAAA;
        exec(mk(1'b0, 1'b0, 5'd5, 5'd3, 5'd7), 1'b1, 1'b1);
        chk(n_rd == 1 && n_wr == 1 && rd_addr == 64'h100, "R10 start while busy ignored",
            64'({n_rd[15:0], n_wr[15:0]}), 64'h0001_0001);
        for (int i = 0; i < 3; i++) @(negedge clk);
        chk(!busy_o && !mem_req_o && mem[9'h020] == 16'hAAAA, "R10 no second operation",
            64'({busy_o, mem_req_o}), 64'd0);
    endtask

    initial begin
        for (int i = 0; i < 32; i++) rf[i] = '0;
        for (int i = 0; i < 512; i++) mem[i] = '0;
        repeat (4) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_basic(0);
        t_basic(3);
        t_orders();
        t_acq_zr();
        t_alias();
        t_sp();
        t_sp_fault();
        t_feat_off();
        t_nomatch();
        t_busy_start();
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule